// File: doc/BRIEF.md
# Instruction Repeat Buffer

This block sits between a processor's fetch stage and its decoder and serves a repeat instruction. When the core asks for a repeat, it supplies a start address, an iteration count and a block length. The buffer reads the block from program memory exactly once, storing one word for each fetch that memory accepts. It then hands the stored words to the decoder again and again, so the core executes the block the requested number of times.

During the replay the buffer makes no program-memory requests. It raises a flag telling the rest of the core that the program-memory bus is free for a data load or store. A stall from the decoder freezes the replay without losing or repeating a word. When the last word has been issued, the buffer pulses a resume strobe together with the address just past the block, and ordinary fetching continues from there.

Top module: `loop_replay_buf`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `pm_req`, `dec_valid`, `bus_free` and `resume_valid` are all 0.
- R2: A start taken in the idle state fetches the block in ascending address order, beginning at `rpt_addr`. Each fetch address is presented on `pm_addr` with `pm_req` high, and only a cycle with `pm_req` and `pm_ack` both high captures a word and advances to the next address.
- R3: The effective block length L equals `rpt_len` when that value is in the range 1 to 8. Both 0 and any value above 8 give L = 8, so exactly L fetches are accepted.
- R4: A count of N issues the block N+1 times. Count 0 issues it once. The k-th word issued (counting from 0) is the memory word at `rpt_addr + (k mod L)`, and exactly (N+1)*L words are issued.
- R5: `pm_req` is never high while `bus_free` is high. `bus_free` rises in the cycle after the final accepted fetch, stays high through the cycle in which the last word is issued, and is low in the cycle after that.
- R6: A word is issued in a cycle with `dec_valid` high and `dec_stall` low. While `dec_stall` is high, `dec_valid` and `dec_instr` hold, so no word is skipped or duplicated.
- R7: In the cycle after the last word is issued, `resume_valid` is high for exactly one cycle, with `resume_addr` equal to `rpt_addr + L`.
- R8: A pulse on `rpt_start` while a repeat is loading or replaying is ignored: the running repeat completes unchanged.
- R9: `dec_valid` is high only while the buffer is replaying, that is, only while `bus_free` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_start | input | 1 | Request a repeat; taken only when idle |
| rpt_addr | input | AW | Address of the first word of the block |
| rpt_count | input | CW | Additional iterations (N gives N+1 passes) |
| rpt_len | input | LENW | Block length; 0 or above DEPTH means DEPTH |
| pm_req | output | 1 | Program-memory fetch request |
| pm_addr | output | AW | Program-memory fetch address |
| pm_rdata | input | IW | Program-memory read data for the current request |
| pm_ack | input | 1 | Fetch accepted this cycle; data valid |
| dec_valid | output | 1 | Instruction presented to the decoder |
| dec_instr | output | IW | Instruction word for the decoder |
| dec_stall | input | 1 | Decoder not accepting this cycle |
| bus_free | output | 1 | Program-memory bus free for data access |
| resume_valid | output | 1 | One-cycle strobe at the end of the repeat |
| resume_addr | output | AW | Address where normal fetching continues |

## Verification
A start sampled at one edge raises `pm_req` on the next cycle. An accepted fetch moves `pm_addr` forward one cycle later. The final accepted fetch brings up `bus_free` and the first replayed word in the next cycle. Each issued word is followed by the next word one cycle later, and the resume strobe follows the last issue by one cycle. The bench drives inputs and samples outputs at the falling edge, and it records each accepted fetch or issued word as it is seen. It then arms a one-shot expectation (bus free, or end strobe with resume address) for the following falling edge, so every check falls in the cycle where the registered result is due. Random acknowledge gaps and decoder stalls are compared against a word sequence computed from the start address, the clamped length and the count.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

  // Controller phases of one repeat.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_REPEAT = 2'd2,
    ST_DONE   = 2'd3
  } lrb_state_e;

endpackage

// File: rtl/lrb_store.sv
// Capture storage for the repeated block: one write port, one
// asynchronous read port, no reset, so it maps onto distributed RAM.
module lrb_store #(
  parameter int IW    = 24,
  parameter int DEPTH = 8,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [IW-1:0]   wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [IW-1:0]   rd_data
);

  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/lrb_seq.sv
// Repeat controller: block load, replay with iteration counting, resume.
module lrb_seq
  import lrb_pkg::*;
#(
  parameter int IW    = 24,
  parameter int AW    = 16,
  parameter int CW    = 8,
  parameter int DEPTH = 8,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LENW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rpt_start,
  input  logic [AW-1:0]   rpt_addr,
  input  logic [CW-1:0]   rpt_count,
  input  logic [LENW-1:0] rpt_len,
  input  logic            pm_ack,
  input  logic [IW-1:0]   pm_rdata,
  input  logic            dec_stall,
  output logic            pm_req,
  output logic [AW-1:0]   pm_addr,
  output logic            dec_valid,
  output logic [IW-1:0]   dec_instr,
  output logic            bus_free,
  output logic            resume_valid,
  output logic [AW-1:0]   resume_addr,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [IW-1:0]   wr_data,
  output logic [IDXW-1:0] rd_idx,
  input  logic [IW-1:0]   rd_data
);

  localparam logic [LENW-1:0] FULL_LEN = LENW'(DEPTH);

  lrb_state_e      state;
  logic [LENW-1:0] len_q;
  logic [AW-1:0]   fetch_addr_q;
  logic [IDXW-1:0] ld_idx;
  logic [IDXW-1:0] rp_idx;
  logic [CW-1:0]   iter_q;
  logic [IW-1:0]   dec_instr_q;

  logic [LENW-1:0] eff_len;
  logic            ld_last;
  logic            rp_last;
  logic            issue;

  // Out-of-range lengths fall back to the full buffer.
  assign eff_len = (rpt_len == '0 || rpt_len > FULL_LEN) ? FULL_LEN : rpt_len;
  assign ld_last = (LENW'(ld_idx) + LENW'(1)) == len_q;
  assign rp_last = (LENW'(rp_idx) + LENW'(1)) == len_q;
  assign issue   = (state == ST_REPEAT) && !dec_stall;

  // Storage ports.
  assign wr_en   = (state == ST_LOAD) && pm_ack;
  assign wr_idx  = ld_idx;
  assign wr_data = pm_rdata;
  assign rd_idx  = (state == ST_REPEAT && !rp_last) ? rp_idx + IDXW'(1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      len_q        <= FULL_LEN;
      fetch_addr_q <= '0;
      ld_idx       <= '0;
      rp_idx       <= '0;
      iter_q       <= '0;
      dec_instr_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (rpt_start) begin
            state        <= ST_LOAD;
            len_q        <= eff_len;
            fetch_addr_q <= rpt_addr;
            iter_q       <= rpt_count;
            ld_idx       <= '0;
          end
        end
        ST_LOAD: begin
          if (pm_ack) begin
            fetch_addr_q <= fetch_addr_q + AW'(1);
            ld_idx       <= ld_idx + IDXW'(1);
            if (ld_last) begin
              state       <= ST_REPEAT;
              rp_idx      <= '0;
              // A one-word block has not reached storage yet: forward it.
              dec_instr_q <= (ld_idx == '0) ? pm_rdata : rd_data;
            end
          end
        end
        ST_REPEAT: begin
          if (!dec_stall) begin
            if (rp_last) begin
              if (iter_q == '0) begin
                state <= ST_DONE;
              end else begin
                iter_q      <= iter_q - CW'(1);
                rp_idx      <= '0;
                dec_instr_q <= rd_data;
              end
            end else begin
              rp_idx      <= rp_idx + IDXW'(1);
              dec_instr_q <= rd_data;
            end
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign pm_req       = (state == ST_LOAD);
  assign pm_addr      = fetch_addr_q;
  assign dec_valid    = (state == ST_REPEAT);
  assign dec_instr    = dec_instr_q;
  assign bus_free     = (state == ST_REPEAT);
  assign resume_valid = (state == ST_DONE);
  assign resume_addr  = fetch_addr_q;

  AST_LOAD_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD) |-> (LENW'(ld_idx) < len_q)); // R2

  AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (len_q >= LENW'(1) && len_q <= FULL_LEN)); // R3

  AST_PASS_RESTART: assert property (@(posedge clk) disable iff (rst)
    (issue && rp_last && iter_q != '0) |=> (rp_idx == '0 && state == ST_REPEAT)); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REPEAT && dec_stall) |=> (state == ST_REPEAT && $stable(dec_instr_q))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_IDLE)); // R7

  AST_START_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(len_q)); // R8

endmodule

// File: rtl/loop_replay_buf.sv
// Instruction repeat buffer: loads a short block once, replays it to the
// decoder and frees the program-memory bus for the replay.
module loop_replay_buf #(
  parameter int IW    = 24,
  parameter int AW    = 16,
  parameter int CW    = 8,
  parameter int DEPTH = 8,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LENW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rpt_start,
  input  logic [AW-1:0]   rpt_addr,
  input  logic [CW-1:0]   rpt_count,
  input  logic [LENW-1:0] rpt_len,
  output logic            pm_req,
  output logic [AW-1:0]   pm_addr,
  input  logic [IW-1:0]   pm_rdata,
  input  logic            pm_ack,
  output logic            dec_valid,
  output logic [IW-1:0]   dec_instr,
  input  logic            dec_stall,
  output logic            bus_free,
  output logic            resume_valid,
  output logic [AW-1:0]   resume_addr
);

  logic            st_wr_en;
  logic [IDXW-1:0] st_wr_idx;
  logic [IW-1:0]   st_wr_data;
  logic [IDXW-1:0] st_rd_idx;
  logic [IW-1:0]   st_rd_data;

  lrb_seq #(.IW(IW), .AW(AW), .CW(CW), .DEPTH(DEPTH)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .rpt_start    (rpt_start),
    .rpt_addr     (rpt_addr),
    .rpt_count    (rpt_count),
    .rpt_len      (rpt_len),
    .pm_ack       (pm_ack),
    .pm_rdata     (pm_rdata),
    .dec_stall    (dec_stall),
    .pm_req       (pm_req),
    .pm_addr      (pm_addr),
    .dec_valid    (dec_valid),
    .dec_instr    (dec_instr),
    .bus_free     (bus_free),
    .resume_valid (resume_valid),
    .resume_addr  (resume_addr),
    .wr_en        (st_wr_en),
    .wr_idx       (st_wr_idx),
    .wr_data      (st_wr_data),
    .rd_idx       (st_rd_idx),
    .rd_data      (st_rd_data)
  );

  lrb_store #(.IW(IW), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (st_wr_en),
    .wr_idx  (st_wr_idx),
    .wr_data (st_wr_data),
    .rd_idx  (st_rd_idx),
    .rd_data (st_rd_data)
  );

  AST_DECODE_ONLY_FREE: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (bus_free && !pm_req)); // R9

  AST_FREE_ENDS_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    (bus_free && !dec_stall && !$past(rst) && $fell(bus_free) == 1'b0) |=> (bus_free || resume_valid)); // R5

endmodule

// File: tb/tb_loop_replay_buf.sv
module tb_loop_replay_buf;

  localparam int IW    = 24;
  localparam int AW    = 16;
  localparam int CW    = 8;
  localparam int DEPTH = 8;
  localparam int LENW  = $clog2(DEPTH + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            rpt_start = 1'b0;
  logic [AW-1:0]   rpt_addr = '0;
  logic [CW-1:0]   rpt_count = '0;
  logic [LENW-1:0] rpt_len = '0;
  logic            pm_req;
  logic [AW-1:0]   pm_addr;
  logic [IW-1:0]   pm_rdata;
  logic            pm_ack = 1'b0;
  logic            dec_valid;
  logic [IW-1:0]   dec_instr;
  logic            dec_stall = 1'b0;
  logic            bus_free;
  logic            resume_valid;
  logic [AW-1:0]   resume_addr;

  int nvec = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  loop_replay_buf #(.IW(IW), .AW(AW), .CW(CW), .DEPTH(DEPTH)) dut (
    .clk (clk), .rst (rst),
    .rpt_start (rpt_start), .rpt_addr (rpt_addr),
    .rpt_count (rpt_count), .rpt_len (rpt_len),
    .pm_req (pm_req), .pm_addr (pm_addr), .pm_rdata (pm_rdata), .pm_ack (pm_ack),
    .dec_valid (dec_valid), .dec_instr (dec_instr), .dec_stall (dec_stall),
    .bus_free (bus_free), .resume_valid (resume_valid), .resume_addr (resume_addr)
  );

  function automatic logic [IW-1:0] pm_word(input logic [AW-1:0] a);
    return IW'({a[7:0] ^ 8'h5A, a});
  endfunction

  function automatic int clamp_len(input int l);
    return (l == 0 || l > DEPTH) ? DEPTH : l;
  endfunction

  assign pm_rdata = pm_word(pm_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [AW-1:0] addr, input int count, input int len,
                          input int stall_pct, input bit poke);
    int eff;
    int total;
    int acks;
    int issued;
    int cyc;
    bit free_due;
    bit end_due;
    bit done;
    logic [AW-1:0] ea;
    eff = clamp_len(len);
    total = (count + 1) * eff;
    acks = 0; issued = 0; cyc = 0;
    free_due = 0; end_due = 0; done = 0;
    @(negedge clk);
    chk(!pm_req && !bus_free && !dec_valid, "R2 idle before start", {29'd0, pm_req, bus_free, dec_valid}, 0);
    rpt_start = 1'b1;
    rpt_addr  = addr;
    rpt_count = CW'(count);
    rpt_len   = LENW'(len);
    while (!done) begin
      @(negedge clk);
      cyc++;
      dec_stall = ($urandom % 100) < stall_pct;
      pm_ack = ($urandom % 3) != 0;
      if (poke && ((acks == 1) || (issued == 2 && total > 4))) begin
        rpt_start = 1'b1;
        rpt_addr  = ~addr;
        rpt_count = CW'(1);
        rpt_len   = LENW'(3);
      end else begin
        rpt_start = 1'b0;
        rpt_addr  = AW'($urandom);
        rpt_len   = LENW'($urandom);
      end
      #1;
      if (free_due) begin
        chk(bus_free && dec_valid, "R5 bus free after final fetch", {30'd0, bus_free, dec_valid}, 3);
        free_due = 0;
      end
      if (end_due) begin
        ea = addr + AW'(eff);
        chk(!bus_free && !dec_valid, "R5 bus released after last issue", {30'd0, bus_free, dec_valid}, 0);
        chk(resume_valid, "R7 resume strobe", {31'd0, resume_valid}, 1);
        chk(resume_addr == ea, "R7 resume address", 32'(resume_addr), 32'(ea));
        done = 1;
      end else begin
        if (pm_req && bus_free) chk(0, "R5 fetch while bus free", 1, 0);
        if (dec_valid && !bus_free) chk(0, "R9 decode outside replay", 1, 0);
        if (dec_valid && acks < eff) chk(0, "R5 replay before load done", acks, eff);
        if (resume_valid) chk(0, "R7 early resume", 1, 0);
        if (pm_req && pm_ack) begin
          ea = addr + AW'(acks);
          chk(pm_addr == ea, "R2 fetch address", 32'(pm_addr), 32'(ea));
          acks++;
          if (acks == eff) free_due = 1;
        end
        if (dec_valid && !dec_stall) begin
          ea = addr + AW'(issued % eff);
          chk(dec_instr == pm_word(ea), "R4 R6 issued word", 32'(dec_instr), 32'(pm_word(ea)));
          issued++;
          if (issued == total) end_due = 1;
        end
      end
      if (cyc > 20000) begin
        chk(0, "R4 case timeout", issued, total);
        done = 1;
      end
    end
    rpt_start = 1'b0;
    pm_ack = 1'b0;
    dec_stall = 1'b0;
    chk(acks == eff, "R3 accepted fetch count", acks, eff);
    chk(issued == total, "R4 issued word count", issued, total);
    @(negedge clk);
    #1;
    chk(!resume_valid && !pm_req && !dec_valid, "R7 R8 strobe one cycle, idle after",
        {29'd0, resume_valid, pm_req, dec_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(!pm_req && !dec_valid && !bus_free && !resume_valid, "R1 state in reset",
        {28'd0, pm_req, dec_valid, bus_free, resume_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(!pm_req && !dec_valid && !bus_free && !resume_valid, "R1 state after reset",
        {28'd0, pm_req, dec_valid, bus_free, resume_valid}, 0);

    // Directed corners.
    run_case(16'h0100, 0, 1, 0, 0);    // R4 count 0, single word
    run_case(16'h0200, 0, 8, 0, 0);    // R3 full block, once
    run_case(16'h0300, 2, 0, 20, 0);   // R3 length 0 clamps to 8
    run_case(16'h0400, 1, 15, 20, 0);  // R3 length 15 clamps to 8
    run_case(16'hFFFE, 3, 5, 30, 0);   // R2 address wrap
    run_case(16'h0500, 255, 1, 0, 0);  // R4 maximum count
    run_case(16'h0600, 3, 5, 60, 1);   // R6 heavy stall, R8 start while busy
    run_case(16'h0700, 2, 2, 90, 1);   // R6 near-constant stall, R8

    // Random mix.
    for (int i = 0; i < 30; i++) begin
      run_case(AW'($urandom), int'($urandom % 12), int'($urandom % 16),
               int'($urandom % 50), bit'($urandom % 2));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule